// File: doc/BRIEF.md
# Iterative Odd-Even Transposition Sorter

This block orders a block of N unsigned words that sit in an internal register bank. One layer of compare-and-swap cells is reused on every clock. On the first sorting cycle the layer works on the pairs that start at an even word. On the next cycle it works on the pairs that start at an odd word. The two pair sets keep alternating on every cycle after that.

The sorter does not run a fixed schedule. It watches the swaps that each layer makes. It stops as soon as an even layer and the odd layer right after it have both left every pair as it was. At that point the completion flag rises, which lets an enclosing controller move on to storing the results.

A host loads all N words in parallel while the block is idle or finished, and then pulses start. The sorted block is always visible on a parallel output.

The controller has three states:
- ST_IDLE: waiting with data loaded. A load stays in ST_IDLE. A start without a load goes to ST_SORT.
- ST_SORT: one layer is applied per cycle. A clean even layer followed by a clean odd layer goes to ST_DONE.
- ST_DONE: finished. A load returns to ST_IDLE. Start has no effect here.

Top module: `oets_sorter`

## Requirements
- R1: After reset, busy and done are 0 and sorted_data is all zeros. The block is in ST_IDLE.
- R2: A load_en pulse taken in ST_IDLE or ST_DONE stores load_data, with word i at bits [i*W +: W]. The stored words appear on sorted_data after the next edge, and done is cleared in the same cycle.
- R3: A start pulse in ST_IDLE with load_en low makes busy read 1 after the next edge. A start that comes together with load_en is dropped.
- R4: When done is 1, sorted_data is in ascending unsigned order, with word 0 the smallest. The words are the same multiset as the words that were loaded.
- R5: The first sorting cycle compares only the pairs (0,1),(2,3),… . The second cycle compares only the pairs (1,2),(3,4),… . The two sets alternate from then on, and a swap happens only when the lower-index word is strictly greater.
- R6: Equal neighbours never count as a swap. An input that is already ascending, with or without duplicates, reaches done after exactly 2 sorting cycles.
- R7: done rises at the end of the first odd layer that made no swap and that followed an even layer that also made no swap. busy lasts at most N+2 cycles when N is even, and N+3 cycles when N is odd.
- R8: While busy, load_en and start are ignored. The result depends only on the block loaded before start. A start in ST_DONE leaves done at 1 and busy at 0.
- R9: done stays at 1 until a load_en is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | N*W | Words to sort, word i at [i*W +: W] |
| start | input | 1 | Begin sorting the loaded block |
| sorted_data | output | N*W | Current contents of the word bank |
| busy | output | 1 | Sorting in progress |
| done | output | 1 | Block is sorted |

## Verification
The assertions check several rules on every cycle. Busy and done are never both high. Done holds until a load. A lone start always leads into sorting. Any block flagged done is in ascending order. No sorting run goes past the phase bound. Two things need the bench scenarios: that the contents are preserved as a permutation, and the exact cycle on which done rises for a given input. The same is true of the layer-by-layer pair pattern, which the bench watches after a single cycle. The same holds for showing that loads during sorting leave the result untouched.

// File: rtl/oets_pkg.sv
package oets_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_DONE = 2'd2
    } oets_state_e;
endpackage

// File: rtl/oets_layer.sv
module oets_layer #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data_in,
    input  logic           odd_phase,
    output logic [N*W-1:0] data_out,
    output logic           any_swap
);
    logic [N-2:0] swap_v;

    for (genvar i = 0; i < N-1; i++) begin : g_pair
        localparam bit EVEN_PAIR = ((i % 2) == 0);
        assign swap_v[i] = (EVEN_PAIR != odd_phase) &&
                           (data_in[i*W +: W] > data_in[(i+1)*W +: W]);
    end

    for (genvar j = 0; j < N; j++) begin : g_word
        if (j == 0) begin : g_first
            assign data_out[j*W +: W] = swap_v[j] ? data_in[(j+1)*W +: W] : data_in[j*W +: W];
        end else if (j == N-1) begin : g_last
            assign data_out[j*W +: W] = swap_v[j-1] ? data_in[(j-1)*W +: W] : data_in[j*W +: W];
        end else begin : g_mid
            assign data_out[j*W +: W] = swap_v[j]   ? data_in[(j+1)*W +: W] :
                                        swap_v[j-1] ? data_in[(j-1)*W +: W] :
                                                      data_in[j*W +: W];
        end
    end

    assign any_swap = |swap_v;
endmodule

// File: rtl/oets_ctrl.sv
module oets_ctrl
    import oets_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic start,
    input  logic any_swap,
    output logic load_take,
    output logic step_en,
    output logic odd_phase,
    output logic busy,
    output logic done
);
    localparam int LIMIT = N + 2 + (N % 2);
    localparam int CW    = $clog2(LIMIT + 1) + 1;

    oets_state_e state_q, state_d;
    logic        even_clean_q;
    logic [CW-1:0] sort_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!load_en && start) state_d = ST_SORT;
            ST_SORT: if (odd_phase_q_w() && even_clean_q && !any_swap) state_d = ST_DONE;
            ST_DONE: if (load_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    function automatic logic odd_phase_q_w();
        return odd_phase;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            odd_phase    <= 1'b0;
            even_clean_q <= 1'b0;
            sort_cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SORT) begin
                odd_phase  <= ~odd_phase;
                sort_cnt_q <= sort_cnt_q + 1'b1;
                if (!odd_phase) even_clean_q <= !any_swap;
            end else begin
                odd_phase    <= 1'b0;
                even_clean_q <= 1'b0;
                sort_cnt_q   <= '0;
            end
        end
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        step_en   = 1'b0;
        load_take = 1'b0;
        unique case (state_q)
            ST_IDLE: load_take = load_en;
            ST_SORT: begin busy = 1'b1; step_en = 1'b1; end
            ST_DONE: begin done = 1'b1; load_take = load_en; end
            default: ;
        endcase
    end

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));
    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load_en) |=> done);
    assert_start_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !load_en) |=> busy);
    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sort_cnt_q < CW'(LIMIT)));
    assert_busy_exits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
endmodule

// File: rtl/oets_sorter.sv
module oets_sorter #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [N*W-1:0] load_data,
    input  logic           start,
    output logic [N*W-1:0] sorted_data,
    output logic           busy,
    output logic           done
);
    logic [N*W-1:0] bank_q;
    logic [N*W-1:0] layer_out;
    logic           any_swap, load_take, step_en, odd_phase;

    oets_layer #(.N(N), .W(W)) u_layer (
        .data_in  (bank_q),
        .odd_phase(odd_phase),
        .data_out (layer_out),
        .any_swap (any_swap)
    );

    oets_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .start    (start),
        .any_swap (any_swap),
        .load_take(load_take),
        .step_en  (step_en),
        .odd_phase(odd_phase),
        .busy     (busy),
        .done     (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bank_q <= '0;
        else if (load_take) bank_q <= load_data;
        else if (step_en)   bank_q <= layer_out;
    end

    assign sorted_data = bank_q;

    function automatic logic is_ascending(input logic [N*W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < N-1; k++)
            if (v[k*W +: W] > v[(k+1)*W +: W]) ok = 1'b0;
        return ok;
    endfunction

    assert_done_ordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> is_ascending(sorted_data));
    assert_load_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_en) |=> (sorted_data != load_data || $past(layer_out) == sorted_data));
endmodule

// File: tb/sim_oets_sorter.sv
module sim_oets_sorter;
    localparam int N = 8;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [63:0] VEC [NV] = '{
        64'h0807_0605_0403_0201,
        64'h0102_0304_0506_0708,
        64'h5555_5555_5555_5555,
        64'h0909_0707_0303_0101,
        64'h3A11_C4F0_0072_9E2B,
        64'h0000_0000_0000_00FF
    };

    logic clk = 1'b0, rst_n = 1'b0, load_en = 1'b0, start = 1'b0;
    logic [N*W-1:0] load_data = '0;
    logic [N*W-1:0] sorted_data;
    logic busy, done;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oets_sorter #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .start(start), .sorted_data(sorted_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_sort(input logic [63:0] v);
        logic [63:0] r = v;
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N-1; b++)
                if (r[b*W +: W] > r[(b+1)*W +: W]) begin
                    logic [W-1:0] t = r[b*W +: W];
                    r[b*W +: W] = r[(b+1)*W +: W];
                    r[(b+1)*W +: W] = t;
                end
        return r;
    endfunction

    function automatic int ref_cycles(input logic [63:0] v);
        logic [63:0] r = v;
        bit even_clean = 0;
        for (int c = 1; c < 64; c++) begin
            bit odd = ((c - 1) % 2) == 1;
            bit sw = 0;
            for (int b = (odd ? 1 : 0); b < N-1; b += 2)
                if (r[b*W +: W] > r[(b+1)*W +: W]) begin
                    logic [W-1:0] t = r[b*W +: W];
                    r[b*W +: W] = r[(b+1)*W +: W];
                    r[(b+1)*W +: W] = t;
                    sw = 1;
                end
            if (odd && even_clean && !sw) return c;
            if (!odd) even_clean = !sw;
        end
        return -1;
    endfunction

    task automatic do_load(input logic [63:0] v);
        load_data = v; load_en = 1'b1;
        @(negedge clk); load_en = 1'b0;
    endtask

    task automatic do_start(output int cycles);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        cycles = 0;
        while (!done && cycles < 40) begin
            @(negedge clk); cycles++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        @(negedge clk); @(negedge clk);
        check(!busy && !done && sorted_data == 0, "R1 reset", {busy, done, sorted_data[61:0]}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            do_load(VEC[k]);
            check(sorted_data == VEC[k] && !done, "R2 load", sorted_data, VEC[k]);
            do_start(cyc);
            check(sorted_data == ref_sort(VEC[k]), "R4 order", sorted_data, ref_sort(VEC[k]));
            check(cyc == ref_cycles(VEC[k]), "R7 cycles", 64'(cyc), 64'(ref_cycles(VEC[k])));
            check(cyc <= N + 2, "R7 bound", 64'(cyc), 64'(N + 2));
        end

        // R6: ascending input with duplicates finishes in 2 cycles
        do_load(64'hF0F0_8080_2020_1010);
        do_start(cyc);
        check(cyc == 2, "R6 presorted", 64'(cyc), 64'd2);

        // R5: one even layer on a reversed block
        do_load(64'h0001_0203_0405_0607);
        start = 1'b1; @(negedge clk); start = 1'b0;
        check(busy, "R3 busy", 64'(busy), 64'd1);
        @(negedge clk);
        check(sorted_data == 64'h0100_0302_0504_0706, "R5 even layer", sorted_data, 64'h0100_0302_0504_0706);
        @(negedge clk);
        check(sorted_data == 64'h0103_0005_0207_0406, "R5 odd layer", sorted_data, 64'h0103_0005_0207_0406);
        // R8: load and start while busy are ignored
        load_data = 64'hFFFF_FFFF_FFFF_FFFF; load_en = 1'b1; start = 1'b1;
        @(negedge clk); load_en = 1'b0; start = 1'b0;
        check(busy, "R8 still busy", 64'(busy), 64'd1);
        cyc = 0;
        while (!done && cyc < 40) begin @(negedge clk); cyc++; end
        check(sorted_data == 64'h0706_0504_0302_0100, "R8 result kept", sorted_data, 64'h0706_0504_0302_0100);

        // R9 and R8: done holds, start in done has no effect
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check(done && !busy, "R9 hold", {62'd0, done, busy}, 64'd2);
        do_load(64'h1122_3344_5566_7788);
        check(!done && sorted_data == 64'h1122_3344_5566_7788, "R9 cleared by load", sorted_data, 64'h1122_3344_5566_7788);

        // R3: start together with load is dropped
        load_data = 64'h0102_0304_0506_0708; load_en = 1'b1; start = 1'b1;
        @(negedge clk); load_en = 1'b0; start = 1'b0;
        check(!busy && sorted_data == 64'h0102_0304_0506_0708, "R3 start with load", {63'd0, busy}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule